// File: doc/BRIEF.md
# Pointer-Addressed Register File

This block is a 64-entry data register file that an instruction never addresses with a literal register number. Each access goes through one of three small pointer banks: one serves read port A, one serves read port B and one serves the write port. Each bank keeps eight 10-bit pointer registers, one programmable modulo length, and its own update arithmetic.

For every access the instruction names a pointer index and an update mode. The selected pointer's low six bits address the file. The pointer is then post-updated in the same cycle. It can stay unchanged, take a signed step, take a signed step that wraps at the bank's modulo length, or have its low k bits reversed for bit-reversed traversal.

Pointers and modulo lengths are loaded only through a set command that carries an immediate value. No path exists between banks, and no path exists from any pointer into the data file.

Top module: `prf_top`

## Requirements
- R1: An active-low asynchronous reset clears ra, rb, all 24 pointers and all three modulo lengths to zero. The data entries keep their contents through reset.
- R2: With rd_a_en high, ra is loaded on the next rising edge with the entry addressed by pointer rd_a_idx of bank A. With rd_a_en low, ra holds its value.
- R3: With rd_b_en high, rb is loaded on the next rising edge with the entry addressed by pointer rd_b_idx of bank B. With rd_b_en low, rb holds its value.
- R4: With wr_en high, wr_data is stored at the entry addressed by pointer wr_idx of bank W. A read issued in a later cycle returns it.
- R5: When a read and a write hit the same entry in one cycle, the read returns the value held before the write.
- R6: Only bits [5:0] of a pointer form the entry address. Bits [9:6] are kept and take part in the pointer arithmetic.
- R7: Mode code 0 (hold) leaves the accessed pointer unchanged.
- R8: Mode code 1 (step) replaces the accessed pointer with pointer + arg, where arg is a signed 10-bit value and the sum wraps modulo 1024.
- R9: Mode code 2 (modulo) uses the bank length n. When n is non-zero, the pointer is below n and |arg| <= n, the result is (pointer + arg) mod n, which lies in [0, n). When n is zero the mode behaves as mode 1.
- R10: Mode code 3 (reverse) reverses the order of the low k bits of the pointer, with k = arg[3:0] and values above 10 treated as 10. The bits above k, and so the number of set bits, are unchanged.
- R11: With cfg_en high, cfg_bank selects 0 = A, 1 = B or 2 = W; the value 3 is ignored. cfg_is_len = 0 loads pointer cfg_idx with cfg_val. cfg_is_len = 1 loads the bank length with cfg_val. The new value applies from the next cycle. An access in the same cycle still uses the old pointer, and the set command overrides that access's post-update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Set command valid |
| cfg_bank | input | 2 | Target bank: 0 A, 1 B, 2 W, 3 none |
| cfg_is_len | input | 1 | 1 loads the modulo length, 0 loads a pointer |
| cfg_idx | input | 3 | Pointer index for a pointer load |
| cfg_val | input | 10 | Immediate value |
| rd_a_en | input | 1 | Load ra |
| rd_a_idx | input | 3 | Bank A pointer used by the read |
| rd_a_mode | input | 2 | Post-update mode of that pointer |
| rd_a_arg | input | 10 | Step (modes 1, 2) or k in bits [3:0] (mode 3) |
| rd_b_en | input | 1 | Load rb |
| rd_b_idx | input | 3 | Bank B pointer used by the read |
| rd_b_mode | input | 2 | Post-update mode of that pointer |
| rd_b_arg | input | 10 | Step or k for bank B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Bank W pointer used by the write |
| wr_mode | input | 2 | Post-update mode of that pointer |
| wr_arg | input | 10 | Step or k for bank W |
| wr_data | input | 32 | Data to store, two 16-bit halves |
| ra | output | 32 | Read register A |
| rb | output | 32 | Read register B |

## Verification
A read enabled before a rising edge shows in ra or rb after that one edge. A write or a pointer post-update made at that edge first affects an access issued in the next cycle. A set command's value likewise applies from the access after its edge.

The bench drives each cycle's stimulus just after a falling edge and updates its own model in the same step. It compares both read registers at the following falling edge, so every result is sampled exactly one edge after its cause. Same-cycle collisions and the priority of set commands over post-updates are therefore seen at that edge.

// File: rtl/prf_pkg.sv
package prf_pkg;

  localparam int PTR_W = 10;
  localparam int KW    = 4;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_STEP = 2'd1,
    UPD_MOD  = 2'd2,
    UPD_REV  = 2'd3
  } upd_e;

  // Signed step, wrap at 2**PTR_W
  function automatic logic [PTR_W-1:0] f_step(input logic [PTR_W-1:0] p,
                                              input logic [PTR_W-1:0] s);
    return p + s;
  endfunction

  // Signed step folded once into [0, n); n == 0 means plain wrap
  function automatic logic [PTR_W-1:0] f_mod(input logic [PTR_W-1:0] p,
                                             input logic [PTR_W-1:0] s,
                                             input logic [PTR_W-1:0] n);
    logic signed [PTR_W+1:0] t;
    logic signed [PTR_W+1:0] nn;
    if (n == '0) return p + s;
    nn = $signed({2'b00, n});
    t  = $signed({2'b00, p}) + $signed({{2{s[PTR_W-1]}}, s});
    if (t[PTR_W+1])  t = t + nn;
    else if (t >= nn) t = t - nn;
    return t[PTR_W-1:0];
  endfunction

  // Reverse the low k bits, k clamped to PTR_W
  function automatic logic [PTR_W-1:0] f_rev(input logic [PTR_W-1:0] p,
                                             input logic [KW-1:0] k);
    logic [KW-1:0]    kc;
    logic [PTR_W-1:0] full;
    logic [PTR_W-1:0] low;
    logic [PTR_W-1:0] mask;
    kc = (k > KW'(PTR_W)) ? KW'(PTR_W) : k;
    for (int i = 0; i < PTR_W; i++) full[i] = p[PTR_W-1-i];
    low  = full >> (KW'(PTR_W) - kc);
    mask = {PTR_W{1'b1}} >> (KW'(PTR_W) - kc);
    return (p & ~mask) | (low & mask);
  endfunction

endpackage

// File: rtl/prf_ptr_bank.sv
module prf_ptr_bank
  import prf_pkg::*;
#(
  parameter int PTRS  = 8,
  parameter int IDX_W = $clog2(PTRS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_en,
  input  logic [IDX_W-1:0]            acc_idx,
  input  upd_e                        acc_mode,
  input  logic [PTR_W-1:0]            acc_arg,
  input  logic                        set_ptr_en,
  input  logic                        set_len_en,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic [PTR_W-1:0]            set_val,
  output logic [PTR_W-1:0]            cur_ptr,
  output logic [PTR_W-1:0]            nxt_ptr,
  output logic [PTR_W-1:0]            len_q,
  output logic [PTRS-1:0][PTR_W-1:0]  ptr_q
);

  always_comb cur_ptr = ptr_q[acc_idx];

  always_comb begin
    case (acc_mode)
      UPD_STEP: nxt_ptr = f_step(cur_ptr, acc_arg);
      UPD_MOD:  nxt_ptr = f_mod(cur_ptr, acc_arg, len_q);
      UPD_REV:  nxt_ptr = f_rev(cur_ptr, acc_arg[KW-1:0]);
      default:  nxt_ptr = cur_ptr;
    endcase
  end

  // Later assignments win: a set command overrides the post-update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      if (acc_en)     ptr_q[acc_idx] <= nxt_ptr;
      if (set_ptr_en) ptr_q[set_idx] <= set_val;
      if (set_len_en) len_q          <= set_val;
    end
  end

endmodule

// File: rtl/prf_data_file.sv
module prf_data_file #(
  parameter int ENTRIES  = 64,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  parameter int AW       = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [AW-1:0]                      wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [RD_PORTS-1:0]                rd_en,
  input  logic [RD_PORTS-1:0][AW-1:0]        rd_addr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]    rd_q
);

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (rd_en[g]) q <= mem[rd_addr[g]];
    end
    assign rd_q[g] = q;
  end

endmodule

// File: rtl/prf_top.sv
module prf_top
  import prf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 32,
  parameter int PTRS    = 8,
  parameter int AW      = $clog2(ENTRIES),
  parameter int IDX_W   = $clog2(PTRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_bank,
  input  logic              cfg_is_len,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PTR_W-1:0]  cfg_val,
  input  logic              rd_a_en,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [1:0]        rd_a_mode,
  input  logic [PTR_W-1:0]  rd_a_arg,
  input  logic              rd_b_en,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic [1:0]        rd_b_mode,
  input  logic [PTR_W-1:0]  rd_b_arg,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_mode,
  input  logic [PTR_W-1:0]  wr_arg,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ra,
  output logic [DATA_W-1:0] rb
);

  localparam int NB = 3;   // bank 0: port A, 1: port B, 2: write

  logic [NB-1:0]                       port_en;
  logic [NB-1:0][IDX_W-1:0]            port_idx;
  logic [NB-1:0][1:0]                  port_mode;
  logic [NB-1:0][PTR_W-1:0]            port_arg;
  logic [NB-1:0][PTR_W-1:0]            port_sel;
  logic [NB-1:0][PTR_W-1:0]            port_nxt;
  logic [NB-1:0][PTR_W-1:0]            bank_len;
  logic [NB-1:0][PTRS-1:0][PTR_W-1:0]  bank_ptr;
  logic [NB-1:0]                       set_ptr_hit;
  logic [NB-1:0]                       set_len_hit;

  assign port_en   = {wr_en,   rd_b_en,   rd_a_en};
  assign port_idx  = {wr_idx,  rd_b_idx,  rd_a_idx};
  assign port_mode = {wr_mode, rd_b_mode, rd_a_mode};
  assign port_arg  = {wr_arg,  rd_b_arg,  rd_a_arg};

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign set_ptr_hit[g] = cfg_en && !cfg_is_len && (cfg_bank == 2'(g));
    assign set_len_hit[g] = cfg_en &&  cfg_is_len && (cfg_bank == 2'(g));

    prf_ptr_bank #(
      .PTRS  (PTRS),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_en     (port_en[g]),
      .acc_idx    (port_idx[g]),
      .acc_mode   (upd_e'(port_mode[g])),
      .acc_arg    (port_arg[g]),
      .set_ptr_en (set_ptr_hit[g]),
      .set_len_en (set_len_hit[g]),
      .set_idx    (cfg_idx),
      .set_val    (cfg_val),
      .cur_ptr    (port_sel[g]),
      .nxt_ptr    (port_nxt[g]),
      .len_q      (bank_len[g]),
      .ptr_q      (bank_ptr[g])
    );
  end

  logic [1:0][AW-1:0]     rd_addr;
  logic [1:0][DATA_W-1:0] rd_q;

  assign rd_addr = {port_sel[1][AW-1:0], port_sel[0][AW-1:0]};

  prf_data_file #(
    .ENTRIES  (ENTRIES),
    .DATA_W   (DATA_W),
    .RD_PORTS (2),
    .AW       (AW)
  ) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (port_sel[2][AW-1:0]),
    .wr_data (wr_data),
    .rd_en   ({rd_b_en, rd_a_en}),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  assign ra = rd_q[0];
  assign rb = rd_q[1];

endmodule

// File: rtl/prf_chk.sv
module prf_chk
  import prf_pkg::*;
#(
  parameter int PTRS   = 8,
  parameter int IDX_W  = $clog2(PTRS),
  parameter int DATA_W = 32
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 cfg_en,
  input logic [1:0]                           cfg_bank,
  input logic                                 cfg_is_len,
  input logic [IDX_W-1:0]                     cfg_idx,
  input logic [PTR_W-1:0]                     cfg_val,
  input logic                                 rd_a_en,
  input logic                                 rd_b_en,
  input logic [DATA_W-1:0]                    ra,
  input logic [DATA_W-1:0]                    rb,
  input logic [2:0]                           port_en,
  input logic [2:0][1:0]                      port_mode,
  input logic [2:0][PTR_W-1:0]                port_arg,
  input logic [2:0][PTR_W-1:0]                port_sel,
  input logic [2:0][PTR_W-1:0]                port_nxt,
  input logic [2:0][PTR_W-1:0]                bank_len,
  input logic [2:0][PTRS-1:0][PTR_W-1:0]      bank_ptr
);

  logic             q_ptr_v, q_len_v;
  logic [1:0]       q_bank;
  logic [IDX_W-1:0] q_idx;
  logic [PTR_W-1:0] q_val;
  logic [PTR_W-1:0] got_ptr, got_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ptr_v <= 1'b0;
      q_len_v <= 1'b0;
      q_bank  <= '0;
      q_idx   <= '0;
      q_val   <= '0;
    end else begin
      q_ptr_v <= cfg_en && !cfg_is_len && (cfg_bank != 2'd3);
      q_len_v <= cfg_en &&  cfg_is_len && (cfg_bank != 2'd3);
      q_bank  <= cfg_bank;
      q_idx   <= cfg_idx;
      q_val   <= cfg_val;
    end
  end

  always_comb begin
    case (q_bank)
      2'd0:    begin got_ptr = bank_ptr[0][q_idx]; got_len = bank_len[0]; end
      2'd1:    begin got_ptr = bank_ptr[1][q_idx]; got_len = bank_len[1]; end
      default: begin got_ptr = bank_ptr[2][q_idx]; got_len = bank_len[2]; end
    endcase
  end

  AST_RA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_a_en |=> $stable(ra)); // R2
  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_b_en |=> $stable(rb)); // R3
  AST_SET_PTR: assert property (@(posedge clk) disable iff (!rst_n) q_ptr_v |-> got_ptr == q_val); // R11
  AST_SET_LEN: assert property (@(posedge clk) disable iff (!rst_n) q_len_v |-> got_len == q_val); // R11

  for (genvar g = 0; g < 3; g++) begin : g_port
    logic [PTR_W-1:0] mag;
    always_comb mag = port_arg[g][PTR_W-1] ? (~port_arg[g] + 1'b1) : port_arg[g];

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      port_en[g] && port_mode[g] == UPD_HOLD |-> port_nxt[g] == port_sel[g]); // R7
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      port_en[g] && port_mode[g] == UPD_MOD && bank_len[g] != '0 &&
      port_sel[g] < bank_len[g] && mag <= bank_len[g] |-> port_nxt[g] < bank_len[g]); // R9
    AST_REV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      port_en[g] && port_mode[g] == UPD_REV |-> $countones(port_nxt[g]) == $countones(port_sel[g])); // R10
  end

endmodule

bind prf_top prf_chk #(
  .PTRS   (PTRS),
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_bank   (cfg_bank),
  .cfg_is_len (cfg_is_len),
  .cfg_idx    (cfg_idx),
  .cfg_val    (cfg_val),
  .rd_a_en    (rd_a_en),
  .rd_b_en    (rd_b_en),
  .ra         (ra),
  .rb         (rb),
  .port_en    (port_en),
  .port_mode  (port_mode),
  .port_arg   (port_arg),
  .port_sel   (port_sel),
  .port_nxt   (port_nxt),
  .bank_len   (bank_len),
  .bank_ptr   (bank_ptr)
);

// File: tb/prf_top_tb_top.sv
module prf_top_tb_top;

  typedef struct packed {
    logic        cfg_en;  logic [1:0] cbank; logic clen; logic [2:0] cidx; logic [9:0] cval;
    logic        a_en;    logic [2:0] a_idx; logic [1:0] a_mode; logic [9:0] a_arg;
    logic        b_en;    logic [2:0] b_idx; logic [1:0] b_mode; logic [9:0] b_arg;
    logic        w_en;    logic [2:0] w_idx; logic [1:0] w_mode; logic [9:0] w_arg;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1,2'd0,1'b0,3'd1,10'd40,  1'b1,3'd1,2'd1,10'd3,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b1,2'd0,1'b1,3'd0,10'd48,  1'b1,3'd1,2'd2,10'd5,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd1,2'd2,10'd5,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd1,2'd2,10'h3FD,  1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd1,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd1,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b1,2'd2,1'b0,3'd2,10'd7,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd2,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b1,2'd0,1'b0,3'd3,10'd7,   1'b0,3'd0,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b1,3'd2,2'd0,10'd0, 32'hDEAD0007},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd3,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b1,3'd2,2'd0,10'd0, 32'hBEEF0007},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd3,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b1,2'd1,1'b0,3'd4,10'h301, 1'b0,3'd0,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd4,2'd3,10'd4,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd4,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd4,2'd3,10'd15,  1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd4,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b1,2'd3,1'b0,3'd4,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd4,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd4,2'd1,10'd100,  1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b1,3'd4,2'd0,10'd0,    1'b0,3'd0,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd5,2'd2,10'h3FE, 1'b0,3'd0,2'd0,10'd0, 32'h0},
    '{1'b0,2'd0,1'b0,3'd0,10'd0,   1'b0,3'd0,2'd0,10'd0,    1'b1,3'd5,2'd0,10'd0,   1'b0,3'd0,2'd0,10'd0, 32'h0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 6, 10, 15: return "R11";
      1, 2, 3, 18, 19: return "R9";
      4, 5:         return "R7";
      7, 9:         return "R4";
      8:            return "R5";
      16, 17:       return "R6/R8";
      default:      return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, cfg_is_len, rd_a_en, rd_b_en, wr_en;
  logic [1:0]  cfg_bank, rd_a_mode, rd_b_mode, wr_mode;
  logic [2:0]  cfg_idx, rd_a_idx, rd_b_idx, wr_idx;
  logic [9:0]  cfg_val, rd_a_arg, rd_b_arg, wr_arg;
  logic [31:0] wr_data, ra, rb;

  always #2 clk = ~clk;   // 250 MHz

  prf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_bank(cfg_bank), .cfg_is_len(cfg_is_len), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_arg(rd_a_arg),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_mode(rd_b_mode), .rd_b_arg(rd_b_arg),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_arg(wr_arg), .wr_data(wr_data),
    .ra(ra), .rb(rb)
  );

  int checks = 0;
  int errors = 0;

  logic [9:0]  m_ptr [3][8];
  logic [9:0]  m_len [3];
  logic [31:0] m_mem [64];
  logic [31:0] e_ra, e_rb;

  function automatic logic [9:0] m_next(input logic [9:0] p, input logic [1:0] md,
                                        input logic [9:0] a, input logic [9:0] n);
    int s, t, kk;
    logic [9:0] r;
    s = a[9] ? int'(a) - 1024 : int'(a);
    case (md)
      2'd0: return p;
      2'd1: return 10'((int'(p) + s + 1024) % 1024);
      2'd2: begin
        if (n == 10'd0) return 10'((int'(p) + s + 1024) % 1024);
        t = (int'(p) + s) % int'(n);
        if (t < 0) t = t + int'(n);
        return 10'(t);
      end
      default: begin
        kk = (a[3:0] > 4'd10) ? 10 : int'(a[3:0]);
        r = p;
        for (int i = 0; i < kk; i++) r[i] = p[kk-1-i];
        return r;
      end
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cfg_en = v.cfg_en; cfg_bank = v.cbank; cfg_is_len = v.clen; cfg_idx = v.cidx; cfg_val = v.cval;
    rd_a_en = v.a_en; rd_a_idx = v.a_idx; rd_a_mode = v.a_mode; rd_a_arg = v.a_arg;
    rd_b_en = v.b_en; rd_b_idx = v.b_idx; rd_b_mode = v.b_mode; rd_b_arg = v.b_arg;
    wr_en = v.w_en; wr_idx = v.w_idx; wr_mode = v.w_mode; wr_arg = v.w_arg; wr_data = v.wdata;
  endtask

  // One cycle: drive after a falling edge, model, check at the next falling edge
  task automatic run(input vec_t v, input string tag);
    drive(v);
    if (v.a_en) e_ra = m_mem[m_ptr[0][v.a_idx][5:0]];
    if (v.b_en) e_rb = m_mem[m_ptr[1][v.b_idx][5:0]];
    if (v.w_en) m_mem[m_ptr[2][v.w_idx][5:0]] = v.wdata;
    if (v.a_en) m_ptr[0][v.a_idx] = m_next(m_ptr[0][v.a_idx], v.a_mode, v.a_arg, m_len[0]);
    if (v.b_en) m_ptr[1][v.b_idx] = m_next(m_ptr[1][v.b_idx], v.b_mode, v.b_arg, m_len[1]);
    if (v.w_en) m_ptr[2][v.w_idx] = m_next(m_ptr[2][v.w_idx], v.w_mode, v.w_arg, m_len[2]);
    if (v.cfg_en && v.cbank != 2'd3) begin
      if (v.clen) m_len[v.cbank] = v.cval;
      else        m_ptr[v.cbank][v.cidx] = v.cval;
    end
    @(posedge clk);
    @(negedge clk);
    chk(ra, e_ra, {tag, " ra"});
    chk(rb, e_rb, {tag, " rb"});
  endtask

  task automatic model_reset();
    for (int b = 0; b < 3; b++) begin
      m_len[b] = '0;
      for (int i = 0; i < 8; i++) m_ptr[b][i] = '0;
    end
    e_ra = '0;
    e_rb = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    drive('0);
    model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    repeat (2) @(negedge clk);
    chk(ra, 32'h0, "R1 ra reset");
    chk(rb, 32'h0, "R1 rb reset");
    rst_n = 1'b1;

    // Fill through W pointer 5 from its reset value 0, step +1
    for (int i = 0; i < 64; i++) begin
      v = '0;
      v.w_en = 1'b1; v.w_idx = 3'd5; v.w_mode = 2'd1; v.w_arg = 10'd1;
      v.wdata = 32'h3C00_0000 + 32'(i) * 32'h0001_0203;
      run(v, "R1/R4");
    end

    // Read back: A pointer 0 counts up, B pointer 2 counts down through 1023
    for (int i = 0; i < 64; i++) begin
      v = '0;
      v.a_en = 1'b1; v.a_idx = 3'd0; v.a_mode = 2'd1; v.a_arg = 10'd1;
      v.b_en = 1'b1; v.b_idx = 3'd2; v.b_mode = 2'd1; v.b_arg = 10'h3FF;
      run(v, "R2/R3/R6/R8");
    end

    for (int i = 0; i < NV; i++) run(TBL[i], tag_of(i));

    // Mid-run reset: pointers and lengths clear, data stays
    @(negedge clk);
    rst_n = 1'b0;
    drive('0);
    @(posedge clk);
    @(negedge clk);
    model_reset();
    chk(ra, 32'h0, "R1 ra second reset");
    chk(rb, 32'h0, "R1 rb second reset");
    rst_n = 1'b1;

    v = '0;
    v.w_en = 1'b1; v.w_idx = 3'd5; v.w_mode = 2'd0; v.wdata = 32'h5A5A_0000;
    v.a_en = 1'b1; v.a_idx = 3'd1; v.a_mode = 2'd2; v.a_arg = 10'd50;
    run(v, "R1/R5");
    v = '0;
    v.a_en = 1'b1; v.a_idx = 3'd1;
    v.b_en = 1'b1; v.b_idx = 3'd7;
    run(v, "R1/R9");

    drive('0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule